// File: doc/BRIEF.md
# Message Descriptor Ring

This block is a register file that software writes through memory-mapped registers to build outgoing messages. A message is sent in two steps. First, software writes descriptor words one at a time, and the block stages them in a circular store. Second, a single launch write commits the whole group at once.

Committed descriptors pass to a consumer port on the DMA side. That port shows the oldest committed word and removes one word on each cycle that it pops. Until a launch commits them, staged words stay invisible to the consumer.

The register interface uses a write strobe, a 3-bit address and a write data word. Reads are combinational from the address. The block reports:
- the free descriptor space, capped at the per-packet maximum;
- the number of staged words, so a context switch can save it;
- a sticky error register for rejected launches.

A launch is illegal in three cases: it declares zero entries, it declares too many entries, or the declared count disagrees with what was staged. An illegal launch commits nothing and discards the staged words. Software can describe the next message in the cycle that follows any launch.

Top module: `desc_ring`

## Requirements
- R1: After reset the consumer shows no valid entry, the staged count and committed count are 0, the space register reads 16 and the error register reads 0.
- R2: A write to address 0 appends its data word to the staged group and raises the staged count (read at address 3) by one. Staged words never make the consumer valid.
- R3: A write to address 1 whose low 8 data bits equal the staged count (1 to 16) commits every staged word at once. In the next cycle the committed count has risen by that number, the staged count is 0 and the consumer is valid.
- R4: The consumer port shows the oldest committed word while valid is high. Each cycle with pop high and valid high removes exactly one word. Words leave in the order they were written, across ring wraps, and a pop while not valid has no effect.
- R5: Address 2 reads the free space: 64 minus committed minus staged words, capped at 16.
- R6: A launch declaring 0 entries sets error bit 0, commits nothing and discards the staged words.
- R7: A launch declaring more than 16 entries sets error bit 1. So does any launch that follows a descriptor write made while 16 words were already staged or while the ring had no free slot. That descriptor write is dropped, and the launch commits nothing and discards the staged words.
- R8: A launch declaring between 1 and 16 entries that differs from the staged count sets error bit 2, commits nothing and discards the staged words.
- R9: Error bits are sticky. A write to address 4 clears exactly the bits that are 1 in its data. Other writes leave the bits unchanged.
- R10: Address 5 reads the committed count in bits 23:16 and the consumer head index in bits 7:0.
- R11: A descriptor write in the cycle right after a launch starts a new group. It is neither part of the launched group nor lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| cons_pop | input | 1 | Consumer removes the head word |
| cons_valid | output | 1 | At least one committed word is present |
| cons_data | output | 32 | Oldest committed descriptor word |

## Verification
Pointer and count errors surface at the ports within one cycle, in three ways:
- A lost or doubled commit shows as a wrong committed count at address 5 right after the launch.
- A misplaced tail or staging index puts a wrong word on cons_data the first time that word reaches the head.
- An error classification fault shows in the error register on the cycle after the launch, together with a staged count that was or was not cleared.

The bench keeps a queue model of the staged and committed words. It compares every popped word and every register read against that model, so a corrupted ring wrap appears at the first pop after the wrap.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

    localparam int LEN_W = 8;

    typedef enum logic [2:0] {
        RA_DESC   = 3'd0,
        RA_LAUNCH = 3'd1,
        RA_SPACE  = 3'd2,
        RA_SAVED  = 3'd3,
        RA_ERR    = 3'd4,
        RA_STATUS = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic mismatch;
        logic too_many;
        logic zero_len;
    } launch_err_t;

    function automatic int unsigned ring_add(int unsigned base, int unsigned inc,
                                             int unsigned depth);
        int unsigned s;
        s = base + inc;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/desc_store.sv
module desc_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/desc_ptrs.sv
module desc_ptrs
    import desc_ring_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int MAX_PKT = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int SCNT_W = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              launch,
    input  logic [LEN_W-1:0]  launch_len,
    input  logic              pop,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  head_idx,
    output logic [CNT_W-1:0]  committed,
    output logic [SCNT_W-1:0] staged,
    output logic [SCNT_W-1:0] space,
    output logic              valid,
    output launch_err_t       err_pulse
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] MAXC_C  = CNT_W'(MAX_PKT);
    localparam logic [LEN_W-1:0] MAXL_C  = LEN_W'(MAX_PKT);

    logic [IDX_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  comm_q;
    logic [SCNT_W-1:0] stg_q;
    logic              over_q;

    logic [CNT_W-1:0]  free_w;
    logic              push_ok, pop_ok, launch_ok;
    launch_err_t       cls;

    // free slots and the capped report
    always_comb begin
        free_w = DEPTH_C - comm_q - CNT_W'(stg_q);
        if (free_w > MAXC_C) space = SCNT_W'(MAX_PKT);
        else                 space = SCNT_W'(free_w);
    end

    assign push_ok = push && !over_q && (stg_q < SCNT_W'(MAX_PKT)) && (free_w != '0);
    assign pop_ok  = pop && (comm_q != '0);
    assign wr_en   = push_ok;
    assign wr_idx  = IDX_W'(ring_add(int'(tail_q), int'(stg_q), DEPTH));

    // launch legality
    always_comb begin
        cls          = '0;
        cls.zero_len = (launch_len == '0);
        cls.too_many = !cls.zero_len && ((launch_len > MAXL_C) || over_q);
        cls.mismatch = !cls.zero_len && !cls.too_many && (launch_len != LEN_W'(stg_q));
    end

    assign launch_ok = launch && (cls == '0);
    assign err_pulse = launch ? cls : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            comm_q <= '0;
            stg_q  <= '0;
            over_q <= 1'b0;
        end else begin
            if (pop_ok) head_q <= IDX_W'(ring_add(int'(head_q), 1, DEPTH));
            if (launch_ok) tail_q <= IDX_W'(ring_add(int'(tail_q), int'(stg_q), DEPTH));
            comm_q <= comm_q + (launch_ok ? CNT_W'(stg_q) : '0) - (pop_ok ? CNT_W'(1) : '0);
            if (launch) begin
                stg_q  <= '0;
                over_q <= 1'b0;
            end else if (push) begin
                if (push_ok) stg_q <= stg_q + SCNT_W'(1);
                else         over_q <= 1'b1;
            end
        end
    end

    assign head_idx  = head_q;
    assign committed = comm_q;
    assign staged    = stg_q;
    assign valid     = (comm_q != '0);

    a_r5_space_cap: assert property (@(posedge clk) disable iff (rst)
        (space <= SCNT_W'(MAX_PKT)));

    a_r5_no_overcommit: assert property (@(posedge clk) disable iff (rst)
        ((comm_q + CNT_W'(stg_q)) <= DEPTH_C));

    a_r3_atomic_commit: assert property (@(posedge clk) disable iff (rst)
        launch_ok |=> (comm_q == CNT_W'($past(comm_q) + CNT_W'($past(stg_q))
                                        - ($past(pop_ok) ? CNT_W'(1) : '0)))
                      && (stg_q == '0));

    a_r6_reject_discards: assert property (@(posedge clk) disable iff (rst)
        (launch && !launch_ok) |=> (stg_q == '0)
            && (comm_q == CNT_W'($past(comm_q) - ($past(pop_ok) ? CNT_W'(1) : '0))));

    a_r4_head_step: assert property (@(posedge clk) disable iff (rst)
        pop_ok |=> (head_q == IDX_W'(ring_add(int'($past(head_q)), 1, DEPTH))));

    a_r4_idle_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && !valid) |=> $stable(head_q));

    a_r7_drop_marks: assert property (@(posedge clk) disable iff (rst)
        (push && !launch && !push_ok) |=> over_q && $stable(stg_q));
endmodule

// File: rtl/desc_regs.sv
module desc_regs
    import desc_ring_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 6,
    parameter int CNT_W   = 7,
    parameter int SCNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  launch_err_t       err_pulse,
    input  logic [SCNT_W-1:0] space,
    input  logic [SCNT_W-1:0] staged,
    input  logic [CNT_W-1:0]  committed,
    input  logic [IDX_W-1:0]  head_idx,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [2:0] err_q;
    logic [2:0] clr_mask;

    assign clr_mask = (bus_wr && bus_addr == RA_ERR) ? bus_wdata[2:0] : 3'b000;

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= (err_q & ~clr_mask) | err_pulse;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_SPACE: bus_rdata[SCNT_W-1:0] = space;
            RA_SAVED: bus_rdata[SCNT_W-1:0] = staged;
            RA_ERR:   bus_rdata[2:0]        = err_q;
            RA_STATUS: begin
                bus_rdata[16 +: CNT_W] = committed;
                bus_rdata[IDX_W-1:0]   = head_idx;
            end
            default:  bus_rdata = '0;
        endcase
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (clr_mask == '0 && err_pulse == '0) |=> $stable(err_q));

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0 && err_pulse == '0) |=> ((err_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/desc_ring.sv
module desc_ring
    import desc_ring_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int MAX_PKT = 16,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cons_pop,
    output logic              cons_valid,
    output logic [DATA_W-1:0] cons_data
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int SCNT_W = $clog2(MAX_PKT + 1);

    logic              push, launch, wr_en;
    logic [IDX_W-1:0]  wr_idx, head_idx;
    logic [CNT_W-1:0]  committed;
    logic [SCNT_W-1:0] staged, space;
    launch_err_t       err_pulse;

    assign push   = bus_wr && (bus_addr == RA_DESC);
    assign launch = bus_wr && (bus_addr == RA_LAUNCH);

    desc_ptrs #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_ptrs (
        .clk(clk), .rst(rst), .push(push), .launch(launch),
        .launch_len(bus_wdata[LEN_W-1:0]), .pop(cons_pop),
        .wr_en(wr_en), .wr_idx(wr_idx), .head_idx(head_idx),
        .committed(committed), .staged(staged), .space(space),
        .valid(cons_valid), .err_pulse(err_pulse)
    );

    desc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(bus_wdata),
        .rd_idx(head_idx), .rd_data(cons_data)
    );

    desc_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .SCNT_W(SCNT_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .err_pulse(err_pulse), .space(space),
        .staged(staged), .committed(committed), .head_idx(head_idx),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: tb/sim_desc_ring.sv
module sim_desc_ring;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cons_pop = 1'b0;
    logic        cons_valid;
    logic [31:0] cons_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] cq[$];
    logic [31:0] sq[$];
    bit          over_m = 0;
    logic [2:0]  err_m = 3'b000;
    int          head_m = 0;

    always #4 clk = ~clk;

    desc_ring u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cons_pop(cons_pop),
        .cons_valid(cons_valid), .cons_data(cons_data)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int space_m();
        int f;
        f = 64 - cq.size() - sq.size();
        return (f > 16) ? 16 : f;
    endfunction

    // one bus/consumer cycle; model updated with the registered effect
    task automatic cyc(bit wr, logic [2:0] a, logic [31:0] d, bit pop);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; cons_pop = pop;
        #1;
        chk("R4 valid", {31'd0, cons_valid}, {31'd0, cq.size() != 0});
        if (cq.size() != 0) chk("R4 data", cons_data, cq[0]);
        begin
            bit do_pop;
            do_pop = pop && cq.size() != 0;
            if (wr && a == 3'd0) begin
                if (!over_m && sq.size() < 16 && (64 - cq.size() - sq.size()) > 0)
                    sq.push_back(d);
                else over_m = 1;
            end
            if (wr && a == 3'd4) err_m = err_m & ~d[2:0];
            if (do_pop) begin
                void'(cq.pop_front());
                head_m = (head_m + 1) % 64;
            end
            if (wr && a == 3'd1) begin
                int n;
                n = int'(d[7:0]);
                if (n == 0) err_m[0] = 1;
                else if (n > 16 || over_m) err_m[1] = 1;
                else if (n != sq.size()) err_m[2] = 1;
                else foreach (sq[i]) cq.push_back(sq[i]);
                sq.delete();
                over_m = 0;
            end
        end
        @(posedge clk); #1;
        bus_wr = 0; cons_pop = 0;
    endtask

    task automatic rd(logic [2:0] a, string tag, logic [31:0] exp);
        @(negedge clk);
        bus_wr = 0; cons_pop = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic check_regs();
        rd(3'd2, "R5 space", 32'(space_m()));
        rd(3'd3, "R2 staged", 32'(sq.size()));
        rd(3'd4, "R9 error", {29'd0, err_m});
        rd(3'd5, "R10 status", (32'(cq.size()) << 16) | 32'(head_m));
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4021);
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        check_regs();
        chk("R1 valid", {31'd0, cons_valid}, 32'd0);

        // R2 staging invisible
        for (int i = 0; i < 3; i++) cyc(1, 3'd0, 32'hA000 + i, 0);
        chk("R2 hidden", {31'd0, cons_valid}, 32'd0);
        check_regs();
        // R3 launch, R11 immediate next describe
        cyc(1, 3'd1, 32'd3, 0);
        chk("R3 visible", {31'd0, cons_valid}, 32'd1);
        cyc(1, 3'd0, 32'hB001, 0);
        cyc(1, 3'd0, 32'hB002, 0);
        check_regs();
        cyc(1, 3'd1, 32'd2, 1);
        check_regs();
        // R4 drain in order, plus pop on empty
        while (cq.size() != 0) cyc(0, 3'd2, 0, 1);
        cyc(0, 3'd2, 0, 1);
        check_regs();

        // R6 zero-length launch
        cyc(1, 3'd0, 32'hC000, 0);
        cyc(1, 3'd1, 32'd0, 0);
        check_regs();
        // R9 clear with no bits, then the bit
        cyc(1, 3'd4, 32'd0, 0);
        rd(3'd4, "R9 keep", 32'd1);
        cyc(1, 3'd4, 32'd1, 0);
        rd(3'd4, "R9 clear", 32'd0);

        // R7 too many staged, and declared beyond maximum
        for (int i = 0; i < 17; i++) cyc(1, 3'd0, 32'hD000 + i, 0);
        check_regs();
        cyc(1, 3'd1, 32'd16, 0);
        rd(3'd4, "R7 overflow", 32'd2);
        cyc(1, 3'd1, 32'd20, 0);
        check_regs();
        cyc(1, 3'd4, 32'h7, 0);

        // R8 mismatch
        cyc(1, 3'd0, 32'hE000, 0);
        cyc(1, 3'd0, 32'hE001, 0);
        cyc(1, 3'd1, 32'd3, 0);
        rd(3'd4, "R8 mismatch", 32'd4);
        check_regs();
        cyc(1, 3'd4, 32'h7, 0);

        // R5 fill the whole ring, then R7 push with no room
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 16; i++) cyc(1, 3'd0, 32'hF000 + p * 16 + i, 0);
            cyc(1, 3'd1, 32'd16, 0);
        end
        check_regs();
        cyc(1, 3'd0, 32'h1234, 0);
        cyc(1, 3'd1, 32'd1, 1);
        check_regs();
        cyc(1, 3'd4, 32'h7, 0);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 45)
                cyc(1, 3'd0, $urandom(), $urandom_range(0, 1) == 1);
            else if (r < 55) begin
                if ($urandom_range(0, 4) != 0) cyc(1, 3'd1, 32'(sq.size()), $urandom_range(0, 1) == 1);
                else cyc(1, 3'd1, 32'($urandom_range(0, 20)), 0);
            end else if (r < 58)
                cyc(1, 3'd4, 32'($urandom_range(0, 7)), 0);
            else
                cyc(0, 3'd2, 0, $urandom_range(0, 2) != 0);
            if (k % 50 == 0) check_regs();
        end
        check_regs();

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule